// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An 8-bit general-purpose I/O port. Each line has a direction bit and an output data latch. A line whose direction bit is 1 is an input. Its pad state passes through a two-flop synchronizer and is what the CPU reads back. A line whose direction bit is 0 is a push-pull output. It drives its latch value, and a read of that line returns the latch rather than the pad.

The CPU side uses one command strobe with an operation code and an 8-bit operand. The operations write the data latch, write the direction register, do set, clear or complement by read-modify-write, and sample a wake-up reference. Two alternate output functions can be switched on by configuration inputs: a tone on bit 3, and a buzzer pair on bits 0 and 1. Each alternate signal is gated by the latch bit of its line. A level wake-up request is raised while any enabled line differs from the sampled reference.

The pull-up option is only a configuration input. It is reflected on a per-line pull-up enable output, and that output is active only on input lines.

Top module: `gpio_port_ctrl`

## Requirements
- R1: `pad_oe` bit i is 1 exactly when direction bit i is 0 (output line). `pad_out` bit i is 0 for every input line. Both are registered and follow the register state one clock later.
- R2: `rd_data` is registered. With `rd_sel`=0, bit i holds the synchronized pad bit if direction bit i is 1, otherwise the latch bit. With `rd_sel`=1, it holds the direction register.
- R3: The latch and the direction register change only on a command. Op 0 loads the latch from `cmd_data`, and op 1 loads the direction register. Each takes effect on the clock edge that samples `cmd_valid`, and the value then holds.
- R4: Synchronous reset sets the direction register to all ones and clears the latch, the wake reference, `pad_out`, `pad_oe`, `pad_pu` and `rd_data`.
- R5: Op 2 (set) loads the latch with port_view OR mask. Op 3 (clear) loads port_view AND NOT mask. Op 4 (complement) loads port_view XOR mask. port_view is the R2 read value with `rd_sel`=0, so input lines copy their pad state into the latch.
- R6: Op codes 6 and 7 change neither the latch, the direction register nor the wake reference.
- R7: With `tone_en`=1 and bit 3 an output, `pad_out[3]` is `tone_in` when latch bit 3 is 1, and 0 when it is 0.
- R8: With `buzz_en`=1 and the lines being outputs, `pad_out[0]` is `buzz_in` AND latch bit 0, and `pad_out[1]` is NOT `buzz_in` AND latch bit 1.
- R9: When an alternate function is on, a pin that is an input keeps normal input behaviour: its `pad_oe` is 0, its `pad_out` is 0, and a read returns its pad.
- R10: `wake_req` is 1 while (synchronized pad XOR reference) AND `wake_mask` is nonzero. Op 5 copies the synchronized pad into the reference, which clears the request.
- R11: A pad change set up before clock edge k first appears on `rd_data` after edge k+2.
- R12: `pad_pu` bit i is `pullup_cfg` bit i AND direction bit i, registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (0..7) |
| cmd_data | input | 8 | Write data or bit mask |
| rd_sel | input | 1 | Read view: 0 port, 1 direction |
| rd_data | output | 8 | Registered read value |
| pad_in | input | 8 | Raw pad state |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pull-up enable per line |
| pullup_cfg | input | 8 | Pull-up option per line |
| tone_en | input | 1 | Tone option on bit 3 |
| tone_in | input | 1 | Tone source signal |
| buzz_en | input | 1 | Buzzer option on bits 0 and 1 |
| buzz_in | input | 1 | Buzzer source signal |
| wake_mask | input | 8 | Lines allowed to raise wake-up |
| wake_req | output | 1 | Wake-up request level |

## Verification
The hardest case to reach is a read-modify-write on a mixed-direction port. The value written back must then hold pad state for the input lines and latch state for the output lines. The stimulus sets a split direction pattern and drives pad and latch values that differ in every bit. It then issues set, clear and complement commands, and finally turns every line into an output, so that the merged latch is visible on `pad_out`. The three-edge wake path is covered by changing a masked bit and an unmasked bit in turn, and the exact two-edge synchronizer latency is checked on the cycles around it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [2:0] OP_WR_DATA = 3'd0;
  localparam logic [2:0] OP_WR_DIR  = 3'd1;
  localparam logic [2:0] OP_SET     = 3'd2;
  localparam logic [2:0] OP_CLR     = 3'd3;
  localparam logic [2:0] OP_CPL     = 3'd4;
  localparam logic [2:0] OP_SAMPLE  = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_in;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic [W-1:0] pad_sync,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] port_view,
  output logic         take_sample
);
  // Input lines show the pad, output lines show the latch.
  assign port_view   = (dir_q & pad_sync) | (~dir_q & latch_q);
  assign take_sample = cmd_valid && (cmd_op == OP_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_WR_DATA: latch_q <= cmd_data;
        OP_WR_DIR:  dir_q   <= cmd_data;
        OP_SET:     latch_q <= port_view | cmd_data;
        OP_CLR:     latch_q <= port_view & ~cmd_data;
        OP_CPL:     latch_q <= port_view ^ cmd_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
  parameter int W        = 8,
  parameter int TONE_BIT = 3,
  parameter int BUZZ_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic         tone_en,
  input  logic         tone_in,
  input  logic         buzz_en,
  input  logic         buzz_in,
  input  logic [W-1:0] pullup_cfg,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  logic [W-1:0] drive;

  for (genvar i = 0; i < W; i++) begin : g_line
    if (i == TONE_BIT) begin : g_tone
      assign drive[i] = tone_en ? (latch_q[i] & tone_in) : latch_q[i];
    end else if (i == BUZZ_BIT) begin : g_buzz_p
      assign drive[i] = buzz_en ? (latch_q[i] & buzz_in) : latch_q[i];
    end else if (i == BUZZ_BIT + 1) begin : g_buzz_n
      assign drive[i] = buzz_en ? (latch_q[i] & ~buzz_in) : latch_q[i];
    end else begin : g_plain
      assign drive[i] = latch_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
    end else begin
      pad_out <= drive & ~dir_q;
      pad_oe  <= ~dir_q;
      pad_pu  <= pullup_cfg & dir_q;
    end
  end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_sample,
  input  logic [W-1:0] pad_sync,
  input  logic [W-1:0] wake_mask,
  output logic [W-1:0] ref_q,
  output logic         wake_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= '0;
      wake_req <= 1'b0;
    end else begin
      if (take_sample) ref_q <= pad_sync;
      wake_req <= |((pad_sync ^ ref_q) & wake_mask);
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int W        = 8,
  parameter int TONE_BIT = 3,
  parameter int BUZZ_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  input  logic [W-1:0] pullup_cfg,
  input  logic         tone_en,
  input  logic         tone_in,
  input  logic         buzz_en,
  input  logic         buzz_in,
  input  logic [W-1:0] wake_mask,
  output logic         wake_req
);
  logic [W-1:0] pad_sync;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] port_view;
  logic [W-1:0] ref_q;
  logic         take_sample;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .d_in(pad_in), .d_sync(pad_sync)
  );

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .pad_sync(pad_sync), .latch_q(latch_q),
    .dir_q(dir_q), .port_view(port_view), .take_sample(take_sample)
  );

  gpio_outmux #(.W(W), .TONE_BIT(TONE_BIT), .BUZZ_BIT(BUZZ_BIT)) u_mux (
    .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q),
    .tone_en(tone_en), .tone_in(tone_in), .buzz_en(buzz_en),
    .buzz_in(buzz_in), .pullup_cfg(pullup_cfg), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  gpio_wake #(.W(W)) u_wake (
    .clk(clk), .rst(rst), .take_sample(take_sample), .pad_sync(pad_sync),
    .wake_mask(wake_mask), .ref_q(ref_q), .wake_req(wake_req)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? dir_q : port_view;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W        = 8,
  parameter int TONE_BIT = 3,
  parameter int BUZZ_BIT = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pad_sync,
  input logic [W-1:0] ref_q,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         tone_en,
  input logic         buzz_en
);
  // R4: the cycle after reset, every line is an input
  a_r4_dir_reset: assert property (@(posedge clk)
    $fell(rst) |-> (dir_q == {W{1'b1}}));

  // R3: without a command the latch holds
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(latch_q));

  // R1: output enable follows the direction register one clock later
  a_r1_oe_from_dir: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pad_oe == ~$past(dir_q)));

  // R6: unused op codes touch no state
  a_r6_ignored_op: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op[2] && cmd_op[1]) |=>
      ($stable(latch_q) && $stable(dir_q) && $stable(ref_q)));

  // R7: tone output forced low when its latch bit is 0
  a_r7_tone_low: assert property (@(posedge clk) disable iff (rst)
    ($past(tone_en) && !$past(dir_q[TONE_BIT]) && !$past(latch_q[TONE_BIT]))
      |-> !pad_out[TONE_BIT]);

  // R8: buzzer pair forced low when latch bits are 0
  a_r8_buzz_low: assert property (@(posedge clk) disable iff (rst)
    ($past(buzz_en) && !$past(latch_q[BUZZ_BIT]) && !$past(latch_q[BUZZ_BIT+1]))
      |-> (pad_out[BUZZ_BIT+1:BUZZ_BIT] == 2'b00));

  // R10: a sample command loads the reference
  a_r10_sample_loads: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5) |=> (ref_q == $past(pad_sync)));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(W), .TONE_BIT(TONE_BIT), .BUZZ_BIT(BUZZ_BIT)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .latch_q(latch_q), .dir_q(dir_q), .pad_sync(pad_sync), .ref_q(ref_q),
  .pad_out(pad_out), .pad_oe(pad_oe), .tone_en(tone_en), .buzz_en(buzz_en)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = 8'h3C;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic [7:0] pullup_cfg = 8'h00;
  logic       tone_en = 1'b0, tone_in = 1'b0, buzz_en = 1'b0, buzz_in = 1'b0;
  logic [7:0] wake_mask = 8'h00;
  logic       wake_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pullup_cfg(pullup_cfg), .tone_en(tone_en), .tone_in(tone_in),
    .buzz_en(buzz_en), .buzz_in(buzz_in), .wake_mask(wake_mask),
    .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [7:0] m_p1, m_p2, m_lat, m_dir, m_ref, m_rd, m_out, m_oe, m_pu;
  logic       m_wake;

  function automatic logic [7:0] drive_of(input logic [7:0] lat, input logic [7:0] dir);
    logic [7:0] d;
    d = lat;
    if (tone_en) d[3] = lat[3] & tone_in;
    if (buzz_en) begin
      d[0] = lat[0] & buzz_in;
      d[1] = lat[1] & ~buzz_in;
    end
    return d & ~dir;
  endfunction

  always @(posedge clk) begin
    logic [7:0] view;
    if (rst) begin
      m_p1 <= 0; m_p2 <= 0; m_lat <= 0; m_dir <= 8'hFF; m_ref <= 0;
      m_rd <= 0; m_out <= 0; m_oe <= 0; m_pu <= 0; m_wake <= 0;
    end else begin
      view = 0;
      for (int i = 0; i < 8; i++) view[i] = m_dir[i] ? m_p2[i] : m_lat[i];
      m_p1 <= pad_in;
      m_p2 <= m_p1;
      if (cmd_valid) begin
        if (cmd_op == 3'd0) m_lat <= cmd_data;
        if (cmd_op == 3'd1) m_dir <= cmd_data;
        if (cmd_op == 3'd2) m_lat <= view | cmd_data;
        if (cmd_op == 3'd3) m_lat <= view & ~cmd_data;
        if (cmd_op == 3'd4) m_lat <= view ^ cmd_data;
        if (cmd_op == 3'd5) m_ref <= m_p2;
      end
      m_rd   <= rd_sel ? m_dir : view;
      m_out  <= drive_of(m_lat, m_dir);
      m_oe   <= ~m_dir;
      m_pu   <= pullup_cfg & m_dir;
      m_wake <= ((m_p2 ^ m_ref) & wake_mask) != 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(pad_oe == m_oe,    "R1 pad_oe model",  pad_oe,  m_oe);
      check(pad_out == m_out,  "R3 pad_out model", pad_out, m_out);
      check(rd_data == m_rd,   "R2 rd_data model", rd_data, m_rd);
      check(pad_pu == m_pu,    "R12 pad_pu model", pad_pu,  m_pu);
      check(wake_req == m_wake,"R10 wake model",   {7'd0, wake_req}, {7'd0, m_wake});
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    settle(3);
    check(pad_oe == 8'h00,  "R4 reset oe",      pad_oe,  8'h00);
    check(pad_out == 8'h00, "R4 reset out",     pad_out, 8'h00);
    check(rd_data == 8'h3C, "R4 reset read pad", rd_data, 8'h3C);
    rd_sel = 1'b1; settle(2);
    check(rd_data == 8'hFF, "R2 dir readback", rd_data, 8'hFF);
    rd_sel = 1'b0;

    do_cmd(3'd0, 8'h5A); settle(2);
    check(pad_out == 8'h00, "R1 inputs drive 0", pad_out, 8'h00);
    check(rd_data == 8'h3C, "R2 input reads pad", rd_data, 8'h3C);
    do_cmd(3'd1, 8'h0F); settle(2);
    check(pad_oe == 8'hF0,  "R1 split oe",   pad_oe,  8'hF0);
    check(pad_out == 8'h50, "R1 split out",  pad_out, 8'h50);
    check(rd_data == 8'h5C, "R2 mixed read", rd_data, 8'h5C);

    // R5: mixed-direction read-modify-write
    do_cmd(3'd2, 8'h01);
    do_cmd(3'd3, 8'h40);
    do_cmd(3'd1, 8'h00); settle(2);
    check(pad_out == 8'h1C, "R5 set/clear merge", pad_out, 8'h1C);
    do_cmd(3'd4, 8'hFF); settle(2);
    check(pad_out == 8'hE3, "R5 complement", pad_out, 8'hE3);

    do_cmd(3'd6, 8'h00);
    do_cmd(3'd7, 8'hFF); settle(2);
    check(pad_out == 8'hE3, "R6 unused op latch", pad_out, 8'hE3);
    check(pad_oe == 8'hFF,  "R6 unused op dir",   pad_oe,  8'hFF);

    pad_in = 8'h81; settle(10);
    check(pad_out == 8'hE3, "R3 latch holds", pad_out, 8'hE3);

    tone_en = 1'b1; tone_in = 1'b1; settle(2);
    check(pad_out[3] == 1'b0, "R7 tone gated low", pad_out, 8'hE3);
    do_cmd(3'd0, 8'h08); settle(2);
    check(pad_out == 8'h08, "R7 tone high", pad_out, 8'h08);
    tone_in = 1'b0; settle(2);
    check(pad_out == 8'h00, "R7 tone low", pad_out, 8'h00);
    tone_en = 1'b0; settle(2);
    check(pad_out == 8'h08, "R7 tone off", pad_out, 8'h08);

    buzz_en = 1'b1; buzz_in = 1'b1;
    do_cmd(3'd0, 8'h03); settle(2);
    check(pad_out == 8'h01, "R8 buzz phase 1", pad_out, 8'h01);
    buzz_in = 1'b0; settle(2);
    check(pad_out == 8'h02, "R8 buzz phase 0", pad_out, 8'h02);
    do_cmd(3'd0, 8'h01); settle(2);
    check(pad_out == 8'h00, "R8 buzz gated", pad_out, 8'h00);

    tone_en = 1'b1; pad_in = 8'h0A;
    do_cmd(3'd0, 8'h0B);
    do_cmd(3'd1, 8'h0B); settle(4);
    check(pad_oe == 8'hF4, "R9 alt input oe", pad_oe, 8'hF4);
    check((pad_out & 8'h0B) == 8'h00, "R9 alt input out", pad_out, 8'h00);
    check((rd_data & 8'h0B) == 8'h0A, "R9 alt input read", rd_data, 8'h0A);
    tone_en = 1'b0; buzz_en = 1'b0;

    do_cmd(3'd1, 8'hFF); settle(4);
    pad_in = 8'h55;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(rd_data == 8'h0A, "R11 not yet visible", rd_data, 8'h0A);
    @(negedge clk);
    check(rd_data == 8'h55, "R11 visible after two", rd_data, 8'h55);

    wake_mask = 8'h0F;
    do_cmd(3'd5, 8'h00); settle(3);
    check(wake_req == 1'b0, "R10 idle after sample", {7'd0, wake_req}, 8'h00);
    pad_in = 8'hD5; settle(5);
    check(wake_req == 1'b0, "R10 masked change", {7'd0, wake_req}, 8'h00);
    pad_in = 8'hD4; settle(5);
    check(wake_req == 1'b1, "R10 enabled change", {7'd0, wake_req}, 8'h01);
    do_cmd(3'd5, 8'h00); settle(3);
    check(wake_req == 1'b0, "R10 cleared by sample", {7'd0, wake_req}, 8'h00);

    pullup_cfg = 8'hFF; settle(2);
    check(pad_pu == 8'hFF, "R12 pull-up inputs", pad_pu, 8'hFF);
    do_cmd(3'd1, 8'h0F); settle(2);
    check(pad_pu == 8'h0F, "R12 pull-up outputs off", pad_pu, 8'h0F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule